// File: doc/BRIEF.md
# Virtual-Address Indirect Branch Retirement Trainer

This block trains a shared conditional direction predictor and a shared target buffer after an indirect branch retires. The branch is viewed as a chain of virtual conditional branches, each with its own virtual address and virtual history. The trainer walks that chain in the same order that lookup used. Each virtual branch is labelled taken or not-taken, depending on whether its stored target matches the real target. A use counter is bumped on the matching entry. If no entry in the chain holds the real target, the target is written into the least-used slot.

Retirement hands over the branch address, the global history captured at prediction time, the resolved target, a flag saying whether the prediction was right, and the iteration that produced the prediction. The trainer then steps one iteration per cycle. It performs a read-modify-write of each 2-bit direction counter through a combinational read port. It reads the target buffer only in iterations that need the stored entry, and it waits on a port grant for each such read. It ends with a one-cycle done pulse. Training is off the critical path, so a new request is taken only while the trainer is idle.

Top module: `vpt_trainer`

## Requirements
- R1: `req_ready` is high only while the trainer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` raised while busy is ignored and causes no table write.
- R2: Iteration k uses virtual address `pc ^ H(k)`, where H(k) is the low PC_W bits of k*0x9E3779B1, so iteration 0 uses the PC itself. It uses virtual history `ghr << k`, truncated to GHR_W bits. The direction index is the low DP_IW bits of the virtual address XOR the zero-extended virtual history. The target buffer address is the virtual address.
- R3: A direction update writes, to the index being read, the 2-bit counter plus one when taken or minus one when not-taken. The counter saturates at 3 and at 0.
- R4: On a correct prediction with predicted iteration p, iterations 0..p-1 are trained not-taken without any target-buffer read, and iteration p is trained taken.
- R5: On a correct prediction, the target buffer is read at iteration p. Its use counter (USE_W bits, saturating at all ones) is incremented only when that entry hits and holds the real target. Otherwise the buffer is left unchanged.
- R6: On a misprediction, each iteration whose entry misses or holds a different target is trained not-taken. The first iteration whose entry holds the real target is trained taken, has its use counter incremented with saturation, and ends training.
- R7: On a misprediction with no match in MAX_ITER iterations, one extra cycle writes the real target with use counter 0 at the iteration whose entry had the lowest use value. A miss counts as 0, and the earliest iteration wins a tie. That iteration's direction counter is then trained taken.
- R8: An iteration that needs a target-buffer read holds `btb_rd_en` high and performs no write while `btb_grant` is low. It proceeds in the first cycle the grant is high.
- R9: `done` is a one-cycle pulse, and `req_ready` is high in the cycle after it. Counting from the accepting edge, done is visible after (iterations walked + 1 if an insertion happened + stalled cycles) clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Retirement training request |
| req_ready | output | 1 | Trainer idle, request can be taken |
| req_pc | input | PC_W | Indirect branch address |
| req_ghr | input | GHR_W | Global history captured at prediction |
| req_tgt | input | TGT_W | Resolved target |
| req_correct | input | 1 | Prediction was correct |
| req_pred_iter | input | ITER_W | Iteration that produced the prediction |
| dp_idx | output | DP_IW | Direction counter index (read and write) |
| dp_rd_ctr | input | 2 | Current counter at dp_idx |
| dp_wr_en | output | 1 | Direction counter write |
| dp_wr_ctr | output | 2 | New counter value |
| btb_addr | output | PC_W | Target buffer address (read and write) |
| btb_rd_en | output | 1 | Target buffer read request |
| btb_grant | input | 1 | Read port granted this cycle |
| btb_rd_hit | input | 1 | Entry present at btb_addr |
| btb_rd_tgt | input | TGT_W | Stored target |
| btb_rd_use | input | USE_W | Stored use counter |
| btb_wr_en | output | 1 | Target buffer write |
| btb_wr_tgt | output | TGT_W | Target to write |
| btb_wr_use | output | USE_W | Use counter to write |
| done | output | 1 | Training finished pulse |

## Verification
A wrong iteration counter or wrong virtual-address state sends direction updates to the wrong counters. The error shows in the predictor table once the same request finishes, and the done pulse also arrives at the wrong cycle, so it is visible within MAX_ITER+1 cycles. A faulty victim choice or a faulty use-counter update leaves a wrong entry or count in the target buffer at the end of that request. A grant that is ignored shows as an early done and a write made while the read port was held.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    typedef enum logic [1:0] {
        TR_IDLE  = 2'd0,
        TR_WALK  = 2'd1,
        TR_PLACE = 2'd2,
        TR_FIN   = 2'd3
    } tr_state_e;

    // Decision for the current cycle of the walk
    typedef struct packed {
        logic dp_write;
        logic dp_taken;
        logic use_bump;
        logic sample;
        logic advance;
        logic to_place;
        logic place;
        logic finish;
    } tr_step_t;

    localparam logic [31:0] HASH_MUL = 32'h9E3779B1;

    // Per-iteration scramble; iteration 0 maps to zero
    function automatic logic [31:0] iter_hash(input logic [31:0] k);
        return k * HASH_MUL;
    endfunction

endpackage

// File: rtl/vpt_vaddr_gen.sv
module vpt_vaddr_gen #(
    parameter int PC_W   = 16,
    parameter int GHR_W  = 8,
    parameter int DP_IW  = 6,
    parameter int ITER_W = 2
) (
    input  logic [PC_W-1:0]   base_pc,
    input  logic [GHR_W-1:0]  base_ghr,
    input  logic [ITER_W-1:0] iter,
    output logic [PC_W-1:0]   vaddr,
    output logic [DP_IW-1:0]  vidx
);
    logic [31:0]      hash_full;
    logic [GHR_W-1:0] vhist;

    always_comb begin
        hash_full = vpt_pkg::iter_hash(32'(iter));
        vaddr     = base_pc ^ PC_W'(hash_full);
        vhist     = base_ghr << iter;
        vidx      = DP_IW'(vaddr ^ PC_W'(vhist));
    end
endmodule

// File: rtl/vpt_sat_step.sv
module vpt_sat_step #(
    parameter int W = 2
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        if (up) nxt = (cur == TOP)  ? cur : cur + W'(1);
        else    nxt = (cur == '0)   ? cur : cur - W'(1);
    end
endmodule

// File: rtl/vpt_victim_track.sv
module vpt_victim_track #(
    parameter int USE_W  = 3,
    parameter int ITER_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic [ITER_W-1:0] cand_iter,
    input  logic [USE_W-1:0]  cand_use,
    output logic [ITER_W-1:0] best_iter
);
    logic              have_q;
    logic [USE_W-1:0]  best_use_q;
    logic [ITER_W-1:0] best_iter_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_q      <= 1'b0;
            best_use_q  <= '0;
            best_iter_q <= '0;
        end else if (sample && (!have_q || cand_use < best_use_q)) begin
            have_q      <= 1'b1;
            best_use_q  <= cand_use;
            best_iter_q <= cand_iter;
        end
    end

    assign best_iter = best_iter_q;
endmodule

// File: rtl/vpt_trainer.sv
module vpt_trainer
    import vpt_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int GHR_W    = 8,
    parameter int TGT_W    = 16,
    parameter int DP_IW    = 6,
    parameter int USE_W    = 3,
    parameter int MAX_ITER = 4,
    parameter int ITER_W   = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [GHR_W-1:0]  req_ghr,
    input  logic [TGT_W-1:0]  req_tgt,
    input  logic              req_correct,
    input  logic [ITER_W-1:0] req_pred_iter,
    output logic [DP_IW-1:0]  dp_idx,
    input  logic [1:0]        dp_rd_ctr,
    output logic              dp_wr_en,
    output logic [1:0]        dp_wr_ctr,
    output logic [PC_W-1:0]   btb_addr,
    output logic              btb_rd_en,
    input  logic              btb_grant,
    input  logic              btb_rd_hit,
    input  logic [TGT_W-1:0]  btb_rd_tgt,
    input  logic [USE_W-1:0]  btb_rd_use,
    output logic              btb_wr_en,
    output logic [TGT_W-1:0]  btb_wr_tgt,
    output logic [USE_W-1:0]  btb_wr_use,
    output logic              done
);
    localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);

    tr_state_e         state_q;
    logic [PC_W-1:0]   pc_q;
    logic [GHR_W-1:0]  ghr_q;
    logic [TGT_W-1:0]  tgt_q;
    logic              correct_q;
    logic [ITER_W-1:0] pred_q;
    logic [ITER_W-1:0] iter_q;

    logic [ITER_W-1:0] best_iter;
    logic [ITER_W-1:0] iter_sel;
    logic [PC_W-1:0]   vaddr;
    logic [DP_IW-1:0]  vidx;
    logic [USE_W-1:0]  use_next;
    logic [USE_W-1:0]  cand_use;
    logic              walking;
    logic              at_pred;
    logic              at_last;
    logic              need_read;
    logic              stall;
    logic              tgt_match;
    logic              accept;
    tr_step_t          step;

    assign walking   = (state_q == TR_WALK);
    assign at_pred   = (iter_q == pred_q);
    assign at_last   = (iter_q == LAST_ITER);
    assign need_read = !correct_q || at_pred;
    assign stall     = walking && need_read && !btb_grant;
    assign tgt_match = btb_rd_hit && (btb_rd_tgt == tgt_q);
    assign accept    = (state_q == TR_IDLE) && req_valid;
    assign iter_sel  = (state_q == TR_PLACE) ? best_iter : iter_q;
    assign cand_use  = btb_rd_hit ? btb_rd_use : '0;

    vpt_vaddr_gen #(
        .PC_W  (PC_W),
        .GHR_W (GHR_W),
        .DP_IW (DP_IW),
        .ITER_W(ITER_W)
    ) u_vaddr (
        .base_pc (pc_q),
        .base_ghr(ghr_q),
        .iter    (iter_sel),
        .vaddr   (vaddr),
        .vidx    (vidx)
    );

    vpt_sat_step #(.W(2)) u_dir_step (
        .cur(dp_rd_ctr),
        .up (step.dp_taken),
        .nxt(dp_wr_ctr)
    );

    vpt_sat_step #(.W(USE_W)) u_use_step (
        .cur(btb_rd_use),
        .up (1'b1),
        .nxt(use_next)
    );

    vpt_victim_track #(
        .USE_W (USE_W),
        .ITER_W(ITER_W)
    ) u_victim (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .sample   (step.sample),
        .cand_iter(iter_q),
        .cand_use (cand_use),
        .best_iter(best_iter)
    );

    // Per-cycle decision
    always_comb begin
        step = '0;
        unique case (state_q)
            TR_WALK: begin
                if (!stall) begin
                    step.dp_write = 1'b1;
                    if (correct_q) begin
                        if (at_pred) begin
                            step.dp_taken = 1'b1;
                            step.use_bump = tgt_match;
                            step.finish   = 1'b1;
                        end else if (at_last) begin
                            step.finish   = 1'b1;
                        end else begin
                            step.advance  = 1'b1;
                        end
                    end else if (tgt_match) begin
                        step.dp_taken = 1'b1;
                        step.use_bump = 1'b1;
                        step.finish   = 1'b1;
                    end else begin
                        step.sample = 1'b1;
                        if (at_last) step.to_place = 1'b1;
                        else         step.advance  = 1'b1;
                    end
                end
            end
            TR_PLACE: begin
                step.dp_write = 1'b1;
                step.dp_taken = 1'b1;
                step.place    = 1'b1;
                step.finish   = 1'b1;
            end
            default: step = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TR_IDLE;
            pc_q      <= '0;
            ghr_q     <= '0;
            tgt_q     <= '0;
            correct_q <= 1'b0;
            pred_q    <= '0;
            iter_q    <= '0;
        end else begin
            unique case (state_q)
                TR_IDLE: begin
                    if (req_valid) begin
                        state_q   <= TR_WALK;
                        pc_q      <= req_pc;
                        ghr_q     <= req_ghr;
                        tgt_q     <= req_tgt;
                        correct_q <= req_correct;
                        pred_q    <= req_pred_iter;
                        iter_q    <= '0;
                    end
                end
                TR_WALK: begin
                    if (step.finish)        state_q <= TR_FIN;
                    else if (step.to_place) state_q <= TR_PLACE;
                    else if (step.advance)  iter_q  <= iter_q + ITER_W'(1);
                end
                TR_PLACE: state_q <= TR_FIN;
                TR_FIN:   state_q <= TR_IDLE;
                default:  state_q <= TR_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == TR_IDLE);
    assign done       = (state_q == TR_FIN);
    assign dp_idx     = vidx;
    assign dp_wr_en   = step.dp_write;
    assign btb_addr   = vaddr;
    assign btb_rd_en  = walking && need_read;
    assign btb_wr_en  = step.use_bump || step.place;
    assign btb_wr_tgt = tgt_q;
    assign btb_wr_use = step.place ? '0 : use_next;

endmodule

// File: rtl/vpt_trainer_chk.sv
module vpt_trainer_chk #(
    parameter int PC_W  = 16,
    parameter int USE_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done,
    input logic             dp_wr_en,
    input logic [1:0]       dp_rd_ctr,
    input logic [1:0]       dp_wr_ctr,
    input logic             btb_rd_en,
    input logic             btb_grant,
    input logic             btb_wr_en,
    input logic [USE_W-1:0] btb_rd_use,
    input logic [USE_W-1:0] btb_wr_use,
    input logic [PC_W-1:0]  btb_addr
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!dp_wr_en && !btb_wr_en && !btb_rd_en));

    a_r3_dir_step: assert property (@(posedge clk) disable iff (rst)
        dp_wr_en |-> (dp_wr_ctr != dp_rd_ctr || dp_rd_ctr == 2'b00 || dp_rd_ctr == 2'b11));

    a_r5_use_not_lower: assert property (@(posedge clk) disable iff (rst)
        (btb_wr_en && btb_rd_en) |-> (btb_wr_use >= btb_rd_use));

    a_r8_stall_no_write: assert property (@(posedge clk) disable iff (rst)
        (btb_rd_en && !btb_grant) |-> (!dp_wr_en && !btb_wr_en));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (btb_rd_en && !btb_grant) |=> (btb_rd_en && $stable(btb_addr)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
endmodule

bind vpt_trainer vpt_trainer_chk #(.PC_W(PC_W), .USE_W(USE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .dp_wr_en  (dp_wr_en),
    .dp_rd_ctr (dp_rd_ctr),
    .dp_wr_ctr (dp_wr_ctr),
    .btb_rd_en (btb_rd_en),
    .btb_grant (btb_grant),
    .btb_wr_en (btb_wr_en),
    .btb_rd_use(btb_rd_use),
    .btb_wr_use(btb_wr_use),
    .btb_addr  (btb_addr)
);

// File: tb/vpt_trainer_tb_top.sv
`timescale 1ns/1ps
module vpt_trainer_tb_top;
    localparam int PW = 16, GW = 8, TW = 16, IW = 6, UW = 3, MI = 4, ITW = 2;
    localparam int DPN = 1 << IW;
    localparam int BTN = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0, req_correct = 1'b0;
    logic [PW-1:0] req_pc = '0;
    logic [GW-1:0] req_ghr = '0;
    logic [TW-1:0] req_tgt = '0;
    logic [ITW-1:0] req_pred_iter = '0;
    logic          req_ready, done;
    logic [IW-1:0] dp_idx;
    logic [1:0]    dp_rd_ctr, dp_wr_ctr;
    logic          dp_wr_en;
    logic [PW-1:0] btb_addr;
    logic          btb_rd_en, btb_grant = 1'b1, btb_rd_hit, btb_wr_en;
    logic [TW-1:0] btb_rd_tgt, btb_wr_tgt;
    logic [UW-1:0] btb_rd_use, btb_wr_use;

    // Tables driven by the DUT
    logic [1:0]    dp_tab [DPN];
    logic          bv [BTN];
    logic [PW-1:0] btag [BTN];
    logic [TW-1:0] btgt [BTN];
    logic [UW-1:0] buse [BTN];
    // Expected tables
    logic [1:0]    e_dp [DPN];
    logic          e_bv [BTN];
    logic [PW-1:0] e_btag [BTN];
    logic [TW-1:0] e_btgt [BTN];
    logic [UW-1:0] e_buse [BTN];

    // Bench-side table access requests
    logic          tb_clr = 1'b0, tb_put = 1'b0;
    logic [1:0]    tb_clr_val = '0;
    logic [PW-1:0] tb_put_addr = '0;
    logic [TW-1:0] tb_put_tgt = '0;
    logic [UW-1:0] tb_put_use = '0;

    int total = 0, bad = 0;

    vpt_trainer #(.PC_W(PW), .GHR_W(GW), .TGT_W(TW), .DP_IW(IW), .USE_W(UW), .MAX_ITER(MI)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_pc(req_pc), .req_ghr(req_ghr), .req_tgt(req_tgt), .req_correct(req_correct),
        .req_pred_iter(req_pred_iter), .dp_idx(dp_idx), .dp_rd_ctr(dp_rd_ctr),
        .dp_wr_en(dp_wr_en), .dp_wr_ctr(dp_wr_ctr), .btb_addr(btb_addr),
        .btb_rd_en(btb_rd_en), .btb_grant(btb_grant), .btb_rd_hit(btb_rd_hit),
        .btb_rd_tgt(btb_rd_tgt), .btb_rd_use(btb_rd_use), .btb_wr_en(btb_wr_en),
        .btb_wr_tgt(btb_wr_tgt), .btb_wr_use(btb_wr_use), .done(done)
    );

    assign dp_rd_ctr  = dp_tab[dp_idx];
    assign btb_rd_hit = bv[btb_addr[3:0]] && (btag[btb_addr[3:0]] == btb_addr);
    assign btb_rd_tgt = btgt[btb_addr[3:0]];
    assign btb_rd_use = buse[btb_addr[3:0]];

    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < DPN; i++) dp_tab[i] <= tb_clr_val;
            for (int j = 0; j < BTN; j++) begin
                bv[j] <= 1'b0; btag[j] <= '0; btgt[j] <= '0; buse[j] <= '0;
            end
        end else if (tb_put) begin
            bv[tb_put_addr[3:0]]   <= 1'b1;
            btag[tb_put_addr[3:0]] <= tb_put_addr;
            btgt[tb_put_addr[3:0]] <= tb_put_tgt;
            buse[tb_put_addr[3:0]] <= tb_put_use;
        end else begin
            if (dp_wr_en) dp_tab[dp_idx] <= dp_wr_ctr;
            if (btb_wr_en) begin
                bv[btb_addr[3:0]]   <= 1'b1;
                btag[btb_addr[3:0]] <= btb_addr;
                btgt[btb_addr[3:0]] <= btb_wr_tgt;
                buse[btb_addr[3:0]] <= btb_wr_use;
            end
        end
    end

    // R2 address and index rules
    function automatic logic [PW-1:0] va(input logic [PW-1:0] pc, input int k);
        logic [31:0] h;
        h = 32'(k) * 32'h9E3779B1;
        return pc ^ h[PW-1:0];
    endfunction

    function automatic logic [IW-1:0] di(input logic [PW-1:0] pc, input logic [GW-1:0] g, input int k);
        logic [GW-1:0] vh;
        logic [PW-1:0] x;
        vh = g << k;
        x  = va(pc, k) ^ {{(PW-GW){1'b0}}, vh};
        return x[IW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tbl_clear(input logic [1:0] v);
        @(negedge clk); tb_clr = 1'b1; tb_clr_val = v;
        @(negedge clk); tb_clr = 1'b0;
        for (int i = 0; i < DPN; i++) e_dp[i] = v;
        for (int j = 0; j < BTN; j++) begin
            e_bv[j] = 1'b0; e_btag[j] = '0; e_btgt[j] = '0; e_buse[j] = '0;
        end
    endtask

    task automatic put(input logic [PW-1:0] a, input logic [TW-1:0] t, input logic [UW-1:0] u);
        @(negedge clk); tb_put = 1'b1; tb_put_addr = a; tb_put_tgt = t; tb_put_use = u;
        @(negedge clk); tb_put = 1'b0;
        e_bv[a[3:0]] = 1'b1; e_btag[a[3:0]] = a; e_btgt[a[3:0]] = t; e_buse[a[3:0]] = u;
    endtask

    function automatic bit e_match(input logic [PW-1:0] a, input logic [TW-1:0] t);
        return e_bv[a[3:0]] && e_btag[a[3:0]] == a && e_btgt[a[3:0]] == t;
    endfunction

    task automatic e_dir(input logic [IW-1:0] i, input bit up);
        if (up) begin if (e_dp[i] != 2'b11) e_dp[i] = e_dp[i] + 2'b01; end
        else    begin if (e_dp[i] != 2'b00) e_dp[i] = e_dp[i] - 2'b01; end
    endtask

    task automatic e_bump(input logic [PW-1:0] a);
        if (e_buse[a[3:0]] != '1) e_buse[a[3:0]] = e_buse[a[3:0]] + 1'b1;
    endtask

    // Expected behaviour from R4..R7; returns edges to done without stalls
    task automatic model(input logic [PW-1:0] pc, input logic [GW-1:0] g, input logic [TW-1:0] t,
                         input bit cor, input int p, output int n);
        int best, bu, u;
        logic [PW-1:0] a;
        if (cor) begin
            for (int k = 0; k < p; k++) e_dir(di(pc, g, k), 1'b0);
            e_dir(di(pc, g, p), 1'b1);
            if (e_match(va(pc, p), t)) e_bump(va(pc, p));
            n = p + 1;
            return;
        end
        best = -1; bu = 0;
        for (int k = 0; k < MI; k++) begin
            a = va(pc, k);
            if (e_match(a, t)) begin
                e_dir(di(pc, g, k), 1'b1);
                e_bump(a);
                n = k + 1;
                return;
            end
            e_dir(di(pc, g, k), 1'b0);
            u = (e_bv[a[3:0]] && e_btag[a[3:0]] == a) ? int'(e_buse[a[3:0]]) : 0;
            if (best < 0 || u < bu) begin best = k; bu = u; end
        end
        a = va(pc, best);
        e_bv[a[3:0]] = 1'b1; e_btag[a[3:0]] = a; e_btgt[a[3:0]] = t; e_buse[a[3:0]] = '0;
        e_dir(di(pc, g, best), 1'b1);
        n = MI + 1;
    endtask

    task automatic cmp_tables(input string req);
        int errs = 0;
        for (int i = 0; i < DPN; i++)
            if (dp_tab[i] !== e_dp[i]) begin
                errs++; $display("FAIL %s dir[%0d] act=%0h exp=%0h", req, i, dp_tab[i], e_dp[i]);
            end
        for (int j = 0; j < BTN; j++)
            if (bv[j] !== e_bv[j] || (e_bv[j] && (btag[j] !== e_btag[j] || btgt[j] !== e_btgt[j]
                                                  || buse[j] !== e_buse[j]))) begin
                errs++;
                $display("FAIL %s btb[%0d] act=%0h/%0h/%0h exp=%0h/%0h/%0h", req, j,
                         btag[j], btgt[j], buse[j], e_btag[j], e_btgt[j], e_buse[j]);
            end
        total++;
        if (errs != 0) bad++;
    endtask

    // Issue one request, count edges to done, check the done pulse (R9)
    task automatic run(input logic [PW-1:0] pc, input logic [GW-1:0] g, input logic [TW-1:0] t,
                       input bit cor, input int p, input int gdelay, input bit poke, output int n);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_ghr = g; req_tgt = t;
        req_correct = cor; req_pred_iter = ITW'(p);
        if (gdelay > 0) btb_grant = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        n = 0;
        while (n < 40) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n >= gdelay) btb_grant = 1'b1;
            if (done) break;
            if (poke && n == 1) begin
                chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
                req_valid = 1'b1; req_pc = pc ^ 16'h0F0F; req_tgt = ~t; req_correct = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        btb_grant = 1'b1;
        @(negedge clk);
        chk(!done && req_ready, "R9 done pulse then ready", {done, req_ready}, 1);
    endtask

    int n, en;

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(!dp_wr_en && !btb_wr_en && !btb_rd_en, "R1 reset no access",
            {dp_wr_en, btb_wr_en, btb_rd_en}, 0);
    endtask

    task automatic t_correct_mid();
        tbl_clear(2'b01);
        put(va(16'h1230, 0), 16'hAAAA, 3'd1);
        put(va(16'h1230, 2), 16'hBEEF, 3'd2);
        model(16'h1230, 8'hA5, 16'hBEEF, 1'b1, 2, en);
        run(16'h1230, 8'hA5, 16'hBEEF, 1'b1, 2, 2, 1'b0, n);
        chk(n == en, "R4 correct p=2 latency, no read before p (R8)", n, en);
        cmp_tables("R4 R2 R5 correct p=2 tables");
    endtask

    task automatic t_mis_hit();
        tbl_clear(2'b10);
        put(va(16'h4C80, 0), 16'h2222, 3'd5);
        put(va(16'h4C80, 1), 16'h1111, 3'd7);
        model(16'h4C80, 8'h3C, 16'h1111, 1'b0, 0, en);
        run(16'h4C80, 8'h3C, 16'h1111, 1'b0, 0, 2, 1'b0, n);
        chk(n == en + 2, "R8 grant stall adds cycles", n, en + 2);
        cmp_tables("R6 R5 mispredict match at 1, use saturates");
    endtask

    task automatic t_mis_insert_miss();
        tbl_clear(2'b01);
        put(va(16'h7700, 0), 16'h9000, 3'd3);
        put(va(16'h7700, 1), 16'h9001, 3'd1);
        put(va(16'h7700, 3), 16'h9003, 3'd0);
        model(16'h7700, 8'h0F, 16'h3333, 1'b0, 0, en);
        run(16'h7700, 8'h0F, 16'h3333, 1'b0, 0, 0, 1'b0, n);
        chk(n == en, "R9 insert latency", n, en);
        chk(bv[va(16'h7700, 2) & 16'hF] && btgt[va(16'h7700, 2) & 16'hF] == 16'h3333,
            "R7 miss slot (earliest zero) receives target", btgt[va(16'h7700, 2) & 16'hF], 16'h3333);
        cmp_tables("R7 insert at missing iteration");
    endtask

    task automatic t_mis_insert_min();
        tbl_clear(2'b00);
        put(va(16'h0950, 0), 16'h8000, 3'd4);
        put(va(16'h0950, 1), 16'h8001, 3'd2);
        put(va(16'h0950, 2), 16'h8002, 3'd6);
        put(va(16'h0950, 3), 16'h8003, 3'd2);
        model(16'h0950, 8'hF0, 16'h4444, 1'b0, 0, en);
        run(16'h0950, 8'hF0, 16'h4444, 1'b0, 0, 0, 1'b0, n);
        chk(n == en, "R7 insert latency", n, en);
        cmp_tables("R7 R3 lowest use, low saturation");
    endtask

    task automatic t_correct_sat();
        tbl_clear(2'b11);
        put(va(16'h2A40, 0), 16'h5555, 3'd6);
        model(16'h2A40, 8'h81, 16'h5555, 1'b1, 0, en);
        run(16'h2A40, 8'h81, 16'h5555, 1'b1, 0, 0, 1'b0, n);
        chk(n == en, "R4 correct p=0 latency", n, en);
        cmp_tables("R3 R5 high saturation and use bump");
    endtask

    task automatic t_correct_nomatch();
        tbl_clear(2'b01);
        put(va(16'h6610, 1), 16'h7777, 3'd3);
        model(16'h6610, 8'h5A, 16'h6666, 1'b1, 1, en);
        run(16'h6610, 8'h5A, 16'h6666, 1'b1, 1, 0, 1'b0, n);
        chk(n == en, "R4 correct p=1 latency", n, en);
        cmp_tables("R5 no use change without match");
    endtask

    task automatic t_busy_ignore();
        tbl_clear(2'b01);
        put(va(16'h3C3C, 3), 16'hCAFE, 3'd0);
        model(16'h3C3C, 8'h66, 16'hCAFE, 1'b1, 3, en);
        run(16'h3C3C, 8'h66, 16'hCAFE, 1'b1, 3, 0, 1'b1, n);
        chk(n == en, "R1 busy request does not disturb latency", n, en);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!dp_wr_en && !btb_wr_en && req_ready, "R1 ignored request leaves no work",
                {dp_wr_en, btb_wr_en, req_ready}, 1);
        end
        cmp_tables("R1 R2 tables reflect first request only");
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL R9 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tb_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; tb_clr = 1'b0;
        @(negedge clk);
        t_reset();
        t_correct_mid();
        t_mis_hit();
        t_mis_insert_miss();
        t_mis_insert_min();
        t_correct_sat();
        t_correct_nomatch();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule